// File: doc/BRIEF.md
# DAC Update Trigger Generator

This block decides when one output channel of a converter card loads its next sample. Two sources can start an update. The first is an internal period timer built from two cascaded down-counters. A prescaler of up to 8 bits divides the system clock, and each of its wraps advances a 16-bit conversion counter. The period is therefore the prescale value times the conversion value, in clock cycles, which gives a 24-bit span. The second source is an external active-low trigger pin. It is brought into the clock domain by a two-flop synchroniser and is accepted only on a falling edge that stays low long enough.

A single source-select input picks which source drives the one-cycle update strobe. When the internal timer is the source, the block also drives an active-low trigger pulse of fixed width on its output pin, so that other equipment can follow the updates. The reload values are taken only at a restart. A restart happens on the cycle the channel becomes enabled, or on a cycle where the reload-write strobe is high while the channel is enabled. Reload values below the shortest supported period are raised to that minimum.

All pins are plain control and status signals. The strobe is a single-cycle event with no handshake, and nothing can hold it back. A consumer must act on it in the cycle it is high.

Top module: `dac_trig_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `update_stb` is 0 and `trig_out_n` is 1.
- R2: In timer mode (`ext_mode` = 0), strobes repeat every P×C cycles, where P is the latched prescale value and C is the latched conversion value.
- R3: At a restart, a prescale value of 0 is taken as 1, and a conversion value below CNT_MIN (default 53) is taken as CNT_MIN.
- R4: A restart happens on the edge where `chan_en` is first sampled high, or on an edge where `reload_wr` and `chan_en` are both high. The first strobe after a restart is high in the cycle that follows the edge P×C cycles after the restart edge. Changing `pre_reload` or `cnt_reload` without a restart has no effect on the period.
- R5: In timer mode, `trig_out_n` goes low in the same cycle as each strobe and stays low for exactly PULSE_LEN cycles (default 4).
- R6: In external mode (`ext_mode` = 1), the strobe comes from `ext_trig_n` alone. If the pin is low at MIN_LOW consecutive clock edges (default 2), the strobe is high in the cycle after the third edge counted from the first low sample. Timer expiries produce no strobe, and `trig_out_n` stays 1.
- R7: A low period shorter than MIN_LOW samples gives no strobe. A long low period gives exactly one strobe. A pin that is already low when the channel is enabled gives no strobe until it has been seen high.
- R8: While `chan_en` is 0, `update_stb` stays 0 and `trig_out_n` stays 1 from the next cycle on.
- R9: While `ext_mode` is held, `update_stb` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; its rising edge restarts the timer |
| ext_mode | input | 1 | Source select: 0 = interval timer, 1 = external pin |
| pre_reload | input | PRE_W (8) | Prescale reload value |
| cnt_reload | input | CNT_W (16) | Conversion-counter reload value |
| reload_wr | input | 1 | Reload-write strobe; restarts the timer when the channel is enabled |
| ext_trig_n | input | 1 | Asynchronous active-low external trigger |
| update_stb | output | 1 | One-cycle update strobe |
| trig_out_n | output | 1 | Active-low trigger output pulse (timer mode only) |

## Verification
The timer strobe is due P×C edges after the restart edge. It is seen in the following cycle because it passes through one output register. The external strobe is due three edges after the first low sample: two synchroniser stages, then the qualification counter and the output register. The output pulse starts in the same cycle as its strobe. The bench drives inputs 2 ns after each rising edge. A behavioural model advances on the same edge from those inputs, and the outputs are compared with the model at every falling edge. Directed checks measure the cycle distance between strobes, and from a restart or pin fall to the next strobe, against these counts.

// File: rtl/dac_trig_pkg.sv
package dac_trig_pkg;
  typedef enum logic {
    SRC_TIMER = 1'b0,
    SRC_EXT   = 1'b1
  } trig_src_e;
endpackage

// File: rtl/dac_trig_interval.sv
module dac_trig_interval #(
  parameter int PRE_W   = 8,
  parameter int CNT_W   = 16,
  parameter int CNT_MIN = 53
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre_reload,
  input  logic [CNT_W-1:0] cnt_reload,
  output logic             fire
);
  localparam logic [CNT_W-1:0] CMIN = CNT_W'(CNT_MIN);
  localparam logic [PRE_W-1:0] PONE = PRE_W'(1);

  logic [PRE_W-1:0] p_ld, pc, pre_eff;
  logic [CNT_W-1:0] c_ld, cc, cnt_eff;
  logic             run, pre_tc;

  // clamp reload values to the shortest supported period
  assign pre_eff = (pre_reload == '0) ? PONE : pre_reload;
  assign cnt_eff = (cnt_reload < CMIN) ? CMIN : cnt_reload;
  assign run     = chan_en & ~restart;
  assign pre_tc  = (pc == '0);
  assign fire    = run & pre_tc & (cc == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_ld <= PONE;
      c_ld <= CMIN;
      pc   <= '0;
      cc   <= '0;
    end else if (restart) begin
      p_ld <= pre_eff;
      c_ld <= cnt_eff;
      pc   <= pre_eff - 1'b1;
      cc   <= cnt_eff - 1'b1;
    end else if (run) begin
      if (pre_tc) begin
        pc <= p_ld - 1'b1;
        cc <= (cc == '0) ? c_ld - 1'b1 : cc - 1'b1;
      end else begin
        pc <= pc - 1'b1;
      end
    end
  end

  assert_tc_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (pc == p_ld - 1'b1) && (cc == c_ld - 1'b1));
  assert_pre_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc < p_ld);
  assert_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (p_ld != '0) && (c_ld >= CMIN));
  assert_restart_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pc == p_ld - 1'b1) && (cc == c_ld - 1'b1));
endmodule

// File: rtl/dac_trig_ext_qual.sv
module dac_trig_ext_qual #(
  parameter int MIN_LOW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic ext_n,
  output logic fire
);
  localparam int LW = $clog2(MIN_LOW + 1);
  localparam logic [LW-1:0] LSAT = LW'(MIN_LOW);
  localparam logic [LW-1:0] LPRE = LW'(MIN_LOW - 1);

  logic          s1, s2;
  logic [LW-1:0] lc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= ext_n;
      s2 <= s1;
    end
  end

  // lc saturated at LSAT means "consumed": wait for a high level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lc <= LSAT;
    else if (!chan_en)   lc <= LSAT;
    else if (s2)         lc <= '0;
    else if (lc != LSAT) lc <= lc + 1'b1;
  end

  assign fire = chan_en & ~s2 & (lc == LPRE);

  assert_once_per_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (lc == LSAT) && !fire);
  assert_rearm_on_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(chan_en) && $past(s2) && chan_en) |-> (lc == '0));
endmodule

// File: rtl/dac_trig_pulse.sv
module dac_trig_pulse #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic start,
  output logic pulse_n
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] PLEN = PW'(PULSE_LEN);

  logic [PW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left <= '0;
    else if (!chan_en)     left <= '0;
    else if (start)        left <= PLEN;
    else if (left != '0)   left <= left - 1'b1;
  end

  assign pulse_n = (left == '0);

  assert_pulse_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !pulse_n);
  assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> pulse_n);
endmodule

// File: rtl/dac_trig_gen.sv
module dac_trig_gen
  import dac_trig_pkg::*;
#(
  parameter int PRE_W     = 8,
  parameter int CNT_W     = 16,
  parameter int CNT_MIN   = 53,
  parameter int MIN_LOW   = 2,
  parameter int PULSE_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             ext_mode,
  input  logic [PRE_W-1:0] pre_reload,
  input  logic [CNT_W-1:0] cnt_reload,
  input  logic             reload_wr,
  input  logic             ext_trig_n,
  output logic             update_stb,
  output logic             trig_out_n
);
  trig_src_e src;
  logic      en_q, restart, tmr_fire, ext_fire, sel_fire;

  assign src     = trig_src_e'(ext_mode);
  assign restart = chan_en & (~en_q | reload_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= chan_en;
  end

  dac_trig_interval #(.PRE_W(PRE_W), .CNT_W(CNT_W), .CNT_MIN(CNT_MIN)) u_tmr (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .restart(restart),
    .pre_reload(pre_reload), .cnt_reload(cnt_reload), .fire(tmr_fire));

  dac_trig_ext_qual #(.MIN_LOW(MIN_LOW)) u_ext (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .ext_n(ext_trig_n),
    .fire(ext_fire));

  dac_trig_pulse #(.PULSE_LEN(PULSE_LEN)) u_pls (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
    .start(tmr_fire && (src == SRC_TIMER)), .pulse_n(trig_out_n));

  assign sel_fire = (src == SRC_EXT) ? ext_fire : tmr_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) update_stb <= 1'b0;
    else        update_stb <= chan_en & sel_fire;
  end

  assert_stb_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (update_stb && $stable(ext_mode)) |=> !update_stb);
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !update_stb);
  assert_ext_no_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && $past(ext_mode) && $past(trig_out_n)) |-> trig_out_n);
endmodule

// File: tb/dac_trig_gen_tb.sv
module dac_trig_gen_tb_top;
  localparam int CNT_MIN   = 53;
  localparam int MIN_LOW   = 2;
  localparam int PULSE_LEN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b0, ext_mode = 1'b0, reload_wr = 1'b0, ext_trig_n = 1'b1;
  logic [7:0]  pre_reload = 8'd1;
  logic [15:0] cnt_reload = 16'd53;
  logic        update_stb, trig_out_n;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  string cur_req = "R1";

  // strobe / pulse monitors
  int stb_count = 0, last_stb = -1, last_gap = 0, dbl_stb = 0, prev_stb = 0;
  int low_run = 0, last_low_run = 0, trig_low_seen = 0;

  // model state
  int m_rem = 0, m_P = 1, m_C = CNT_MIN, m_pulse = 0, m_low = 0;
  int d1 = 1, d2 = 1;
  bit m_en_q = 0, m_armed = 0, m_stb = 0;

  dac_trig_gen dut_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .ext_mode(ext_mode),
    .pre_reload(pre_reload), .cnt_reload(cnt_reload), .reload_wr(reload_wr),
    .ext_trig_n(ext_trig_n), .update_stb(update_stb), .trig_out_n(trig_out_n));

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rem = 0; m_P = 1; m_C = CNT_MIN; m_pulse = 0; m_low = 0;
      d1 = 1; d2 = 1; m_en_q = 0; m_armed = 0; m_stb = 0;
    end else begin
      bit rs, tf, ef;
      rs = chan_en && (!m_en_q || reload_wr);
      tf = chan_en && !rs && (m_rem == 0);
      ef = chan_en && m_armed && (d2 == 0) && (m_low + 1 == MIN_LOW);
      m_stb = chan_en && (ext_mode ? ef : tf);
      if (!chan_en) m_pulse = 0;
      else if (!ext_mode && tf) m_pulse = PULSE_LEN;
      else if (m_pulse > 0) m_pulse--;
      if (rs) begin
        m_P = (pre_reload == 0) ? 1 : int'(pre_reload);
        m_C = (cnt_reload < CNT_MIN) ? CNT_MIN : int'(cnt_reload);
        m_rem = m_P * m_C - 1;
      end else if (chan_en) begin
        m_rem = (m_rem == 0) ? m_P * m_C - 1 : m_rem - 1;
      end
      if (!chan_en) m_armed = 0;
      else if (d2 == 1) begin m_armed = 1; m_low = 0; end
      else begin
        if (ef) m_armed = 0;
        m_low++;
      end
      d2 = d1; d1 = int'(ext_trig_n);
      m_en_q = chan_en;
    end
  end

  // compare against the model and monitor away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check({cur_req, " strobe vs model"}, int'(update_stb), int'(m_stb));
      check({cur_req, " trig_out_n vs model"}, int'(trig_out_n), (m_pulse == 0) ? 1 : 0);
      if (update_stb) begin
        stb_count++;
        if (last_stb >= 0) last_gap = cyc - last_stb;
        last_stb = cyc;
      end
      if (update_stb && prev_stb) dbl_stb++;
      prev_stb = int'(update_stb);
      if (!trig_out_n) begin low_run++; trig_low_seen = 1; end
      else if (low_run != 0) begin last_low_run = low_run; low_run = 0; end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(10 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int c0, wr_cyc;
    step(3);
    check("R1 reset strobe", int'(update_stb), 0);
    check("R1 reset trig_out_n", int'(trig_out_n), 1);
    rst_n = 1'b1;
    step(1);
    check("R1 first cycle strobe", int'(update_stb), 0);
    step(1);

    // R2: timer period P*C with P=2, C=60
    cur_req = "R2"; pre_reload = 8'd2; cnt_reload = 16'd60; chan_en = 1'b1;
    wr_cyc = cyc + 1;
    step(130);
    check("R4 first strobe after enable", last_stb - wr_cyc, 120);
    step(300);
    check("R2 strobe interval", last_gap, 120);

    // R5: trigger output width in timer mode
    cur_req = "R5";
    check("R5 output low width", last_low_run, PULSE_LEN);

    // R4: port change without restart has no effect
    cur_req = "R4"; cnt_reload = 16'd100;
    step(300);
    check("R4 period unchanged without reload_wr", last_gap, 120);

    // R3/R4: clamped reload applied at restart
    cur_req = "R3"; pre_reload = 8'd0; cnt_reload = 16'd10; reload_wr = 1'b1;
    wr_cyc = cyc + 1;
    step(1); reload_wr = 1'b0;
    step(60);
    check("R4 first strobe after reload_wr", last_stb - wr_cyc, CNT_MIN);
    step(200);
    check("R3 clamped interval", last_gap, CNT_MIN);

    // R8: disabled
    cur_req = "R8"; chan_en = 1'b0;
    step(2); c0 = stb_count;
    step(200);
    check("R8 no strobe when disabled", stb_count - c0, 0);
    check("R8 trig_out_n high when disabled", int'(trig_out_n), 1);

    // R6: external mode, long low
    cur_req = "R6"; ext_mode = 1'b1; chan_en = 1'b1;
    step(10); c0 = stb_count; trig_low_seen = 0;
    ext_trig_n = 1'b0; wr_cyc = cyc;
    step(8);
    check("R6 external strobe latency", last_stb - wr_cyc, 4);
    step(150);
    check("R7 one strobe per long low", stb_count - c0, 1);
    check("R6 trig_out_n idle in external mode", trig_low_seen, 0);

    // R7: one-sample glitch ignored
    cur_req = "R7"; ext_trig_n = 1'b1;
    step(5); c0 = stb_count;
    ext_trig_n = 1'b0; step(1); ext_trig_n = 1'b1;
    step(10);
    check("R7 glitch ignored", stb_count - c0, 0);

    // R7: pin low at enable is not a trigger
    chan_en = 1'b0; ext_trig_n = 1'b0;
    step(5); c0 = stb_count;
    chan_en = 1'b1;
    step(20);
    check("R7 low at enable ignored", stb_count - c0, 0);
    ext_trig_n = 1'b1; step(5);
    ext_trig_n = 1'b0; step(10);
    check("R7 trigger after high seen", stb_count - c0, 1);

    // R9: never two strobes in a row
    cur_req = "R9";
    check("R9 no back-to-back strobes", dbl_stb, 0);
    summary();
  end
endmodule